// File: doc/BRIEF.md
# Doorbell Mailbox Register File

This block is a small register file reached over a byte-wide register bus (address, write data, write strobe, read strobe, read data), the kind of bus an SMBus target front end would drive. A host loads a command code and a 32-bit operand into inbound message bytes. It then rings a doorbell by writing a trigger value to the software interrupt register. The block raises a one-cycle request toward a firmware-side port, which carries the command code and the operand.

When the firmware finishes, it pulses a completion strobe together with a 32-bit result. The block stores the result in outbound message bytes, sets a completion flag in the status register and, unless the mask bit in the control register is set, asserts an active-high alert. The host reads the result back, then clears the flag by writing a one to its bit.

A doorbell that arrives while a command is still with the firmware is kept as one pending request. That request is handed to the firmware immediately after the current command completes.

Top module: `mbox_regfile`

## Requirements
- R1: After reset the control register (address 0x01) reads 0x10 and every other mapped register reads 0x00; fw_bell and alert are low.
- R2: The control register (0x01), the inbound bytes 0 to 7 (0x38 to 0x3F) and the software interrupt register (0x40) read back the last byte written to them. Writing 0x80 to inbound byte 7 (0x3F) as a service marker has no effect other than storing it.
- R3: Reads from unmapped addresses return 0x00, and writes to them change nothing. Outbound bytes (0x30 to 0x37) cannot be written from the bus.
- R4: Writing 0x01 to address 0x40 while no command is in flight drives fw_bell high for exactly the one cycle after the write. Any other value written there produces no pulse.
- R5: fw_cmd equals inbound byte 0 (0x38). fw_operand equals inbound bytes 1 to 4 (0x39 to 0x3C), with 0x39 as the least significant byte.
- R6: A fw_done strobe while a command is in flight loads fw_result into outbound bytes 1 to 4 (0x31 = least significant, 0x34 = most significant) and sets status bit 1. Outbound bytes 0, 5, 6 and 7 read 0x00.
- R7: Writing a 1 to status bit 1 clears it, and writing a 0 leaves it unchanged. Other status bits read 0. If a completion and a clearing write fall in the same cycle, the bit ends set.
- R8: alert is high exactly when status bit 1 is set and control bit 4 is 0.
- R9: Doorbells rung while a command is in flight collapse into a single pending request. One fw_bell pulse follows in the cycle after that command's fw_done, and no more.
- R10: fw_done while no command is in flight is ignored: the outbound bytes and the status register keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; bus_rdata is valid in the same cycle |
| bus_rdata | output | 8 | Read data, 0x00 when no read |
| fw_bell | output | 1 | One-cycle doorbell request to the firmware |
| fw_cmd | output | 8 | Command code from inbound byte 0 |
| fw_operand | output | 32 | Operand from inbound bytes 1 to 4 |
| fw_done | input | 1 | Firmware completion strobe |
| fw_result | input | 32 | Firmware result, captured on an accepted fw_done |
| alert | output | 1 | Active-high alert |

## Verification
Directed sequences cover three cases: an idle doorbell, a burst of doorbells during a busy command, and a completion with nothing in flight. Only the pending-request logic and the in-flight gate tell these three cases apart. Results with four distinct bytes, such as 0xA1B2C3D4, expose any swapped or shifted byte lane in the outbound and operand mapping. Status writes of 0x00, 0xFD and 0x02 separate write-one-to-clear from a plain write. A completion that lands in the same cycle as a clear shows which of the two wins. Random rounds then vary the command, operand, result and mask bit, checking alert against the flag and mask in every combination.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned MSG_BYTES  = 8;
    localparam int unsigned OPND_BYTES = 4;
    localparam int unsigned OPND_FIRST = 1;
    localparam int unsigned IDX_W      = $clog2(MSG_BYTES);

    localparam logic [7:0] A_CTRL     = 8'h01;
    localparam logic [7:0] A_STAT     = 8'h02;
    localparam logic [7:0] A_OUT_BASE = 8'h30;
    localparam logic [7:0] A_IN_BASE  = 8'h38;
    localparam logic [7:0] A_SWI      = 8'h40;

    localparam logic [7:0] RING_VALUE = 8'h01;
    localparam logic [7:0] CTRL_RESET = 8'h10;
    localparam int unsigned MASK_BIT  = 4;
    localparam int unsigned FLAG_BIT  = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_OUT,
        SEL_IN,
        SEL_SWI
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e         sel;
        logic [IDX_W-1:0] idx;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [7:0] a);
        reg_dec_t   d;
        logic [7:0] off;
        d.sel = SEL_NONE;
        d.idx = '0;
        if (a == A_CTRL) begin
            d.sel = SEL_CTRL;
        end else if (a == A_STAT) begin
            d.sel = SEL_STAT;
        end else if (a == A_SWI) begin
            d.sel = SEL_SWI;
        end else if (a >= A_OUT_BASE && a < A_OUT_BASE + 8'(MSG_BYTES)) begin
            off   = a - A_OUT_BASE;
            d.sel = SEL_OUT;
            d.idx = off[IDX_W-1:0];
        end else if (a >= A_IN_BASE && a < A_IN_BASE + 8'(MSG_BYTES)) begin
            off   = a - A_IN_BASE;
            d.sel = SEL_IN;
            d.idx = off[IDX_W-1:0];
        end
        return d;
    endfunction

endpackage

// File: rtl/mbox_inbound.sv
module mbox_inbound
    import mbox_pkg::*;
#(
    parameter int unsigned N = MSG_BYTES,
    parameter int unsigned W = BYTE_W,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [W-1:0]        wr_data,
    output logic [N-1:0][W-1:0] bytes_q
);

    for (genvar i = 0; i < N; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                bytes_q[i] <= '0;
            end else if (wr_en && wr_idx == IW'(i)) begin
                bytes_q[i] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/mbox_outbound.sv
module mbox_outbound
    import mbox_pkg::*;
#(
    parameter int unsigned N     = MSG_BYTES,
    parameter int unsigned W     = BYTE_W,
    parameter int unsigned FIRST = OPND_FIRST,
    parameter int unsigned OPB   = OPND_BYTES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [OPB*W-1:0]    result,
    output logic [N-1:0][W-1:0] bytes_q
);

    for (genvar i = 0; i < N; i++) begin : g_byte
        if (i >= FIRST && i < FIRST + OPB) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    bytes_q[i] <= '0;
                end else if (load) begin
                    bytes_q[i] <= result[(i-FIRST)*W +: W];
                end
            end
        end else begin : g_zero
            assign bytes_q[i] = '0;
        end
    end

    // R6: least significant result byte lands in the first lane
    a_r6_low_lane: assert property (@(posedge clk) disable iff (rst)
        load |=> bytes_q[FIRST] == $past(result[W-1:0]));

    // R6: most significant result byte lands in the last lane
    a_r6_high_lane: assert property (@(posedge clk) disable iff (rst)
        load |=> bytes_q[FIRST+OPB-1] == $past(result[OPB*W-1 -: W]));

endmodule

// File: rtl/mbox_sequencer.sv
module mbox_sequencer (
    input  logic clk,
    input  logic rst,
    input  logic ring,
    input  logic fw_done,
    input  logic clr,
    output logic fw_bell,
    output logic busy,
    output logic done_flag
);

    logic busy_q, pend_q, bell_q, flag_q;
    logic busy_n, pend_n, bell_n, flag_n;
    logic accept;

    assign accept = fw_done && busy_q;

    always_comb begin
        busy_n = busy_q;
        pend_n = pend_q;
        bell_n = 1'b0;
        flag_n = flag_q;
        if (accept) begin
            flag_n = 1'b1;
            if (pend_q || ring) begin
                bell_n = 1'b1;
                pend_n = 1'b0;
            end else begin
                busy_n = 1'b0;
            end
        end else begin
            if (clr) flag_n = 1'b0;
            if (busy_q) begin
                if (ring) pend_n = 1'b1;
            end else if (ring) begin
                bell_n = 1'b1;
                busy_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
            bell_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            busy_q <= busy_n;
            pend_q <= pend_n;
            bell_q <= bell_n;
            flag_q <= flag_n;
        end
    end

    assign fw_bell   = bell_q;
    assign busy      = busy_q;
    assign done_flag = flag_q;

    // R9: a stored request only exists behind a command in flight
    a_r9_pend_in_flight: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> busy_q);

    // R4: every pulse is caused by a doorbell or a completion
    a_r4_bell_cause: assert property (@(posedge clk) disable iff (rst)
        fw_bell |-> $past(ring || fw_done));

    // R4: a pulse always marks a command as in flight
    a_r4_bell_busy: assert property (@(posedge clk) disable iff (rst)
        fw_bell |-> busy_q);

    // R6: an accepted completion sets the flag
    a_r6_done_sets_flag: assert property (@(posedge clk) disable iff (rst)
        accept |=> done_flag);

    // R7: a clearing write without completion clears the flag
    a_r7_w1c: assert property (@(posedge clk) disable iff (rst)
        (clr && !fw_done) |=> !done_flag);

endmodule

// File: rtl/mbox_regfile.sv
module mbox_regfile
    import mbox_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [7:0]                 bus_addr,
    input  logic [BYTE_W-1:0]          bus_wdata,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    output logic [BYTE_W-1:0]          bus_rdata,
    output logic                       fw_bell,
    output logic [BYTE_W-1:0]          fw_cmd,
    output logic [OPND_BYTES*BYTE_W-1:0] fw_operand,
    input  logic                       fw_done,
    input  logic [OPND_BYTES*BYTE_W-1:0] fw_result,
    output logic                       alert
);

    reg_dec_t dec;
    logic [BYTE_W-1:0] ctrl_q, swi_q;
    logic [MSG_BYTES-1:0][BYTE_W-1:0] in_bytes, out_bytes;
    logic ring, clr, busy, done_flag, in_wr;

    assign dec   = decode_addr(bus_addr);
    assign in_wr = bus_wr && dec.sel == SEL_IN;
    assign ring  = bus_wr && dec.sel == SEL_SWI && bus_wdata == RING_VALUE;
    assign clr   = bus_wr && dec.sel == SEL_STAT && bus_wdata[FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            swi_q  <= '0;
        end else if (bus_wr) begin
            if (dec.sel == SEL_CTRL) ctrl_q <= bus_wdata;
            if (dec.sel == SEL_SWI)  swi_q  <= bus_wdata;
        end
    end

    mbox_inbound #(.N(MSG_BYTES), .W(BYTE_W)) u_inbound (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_wr),
        .wr_idx  (dec.idx),
        .wr_data (bus_wdata),
        .bytes_q (in_bytes)
    );

    mbox_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .ring      (ring),
        .fw_done   (fw_done),
        .clr       (clr),
        .fw_bell   (fw_bell),
        .busy      (busy),
        .done_flag (done_flag)
    );

    mbox_outbound #(
        .N(MSG_BYTES), .W(BYTE_W), .FIRST(OPND_FIRST), .OPB(OPND_BYTES)
    ) u_outbound (
        .clk     (clk),
        .rst     (rst),
        .load    (fw_done && busy),
        .result  (fw_result),
        .bytes_q (out_bytes)
    );

    assign fw_cmd = in_bytes[0];
    always_comb begin
        for (int k = 0; k < OPND_BYTES; k++) begin
            fw_operand[k*BYTE_W +: BYTE_W] = in_bytes[OPND_FIRST + k];
        end
    end

    assign alert = done_flag && !ctrl_q[MASK_BIT];

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (dec.sel)
                SEL_CTRL: bus_rdata = ctrl_q;
                SEL_STAT: bus_rdata[FLAG_BIT] = done_flag;
                SEL_OUT:  bus_rdata = out_bytes[dec.idx];
                SEL_IN:   bus_rdata = in_bytes[dec.idx];
                SEL_SWI:  bus_rdata = swi_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R8: alert only rises after a completion or a control write
    a_r8_alert_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(alert) |-> ($past(fw_done) || $past(bus_wr && bus_addr == A_CTRL)));

    // R10: completion without a command in flight leaves outbound data alone
    a_r10_stray_done: assert property (@(posedge clk) disable iff (rst)
        (fw_done && !busy) |=> $stable(out_bytes));

    // R3: bus writes to outbound bytes have no effect
    a_r3_outbound_ro: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && dec.sel == SEL_OUT && !fw_done) |=> $stable(out_bytes));

endmodule

// File: tb/test_mbox_regfile.sv
`timescale 1ns/1ps
module test_mbox_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic        fw_bell, fw_done = 1'b0, alert;
    logic [7:0]  fw_cmd;
    logic [31:0] fw_operand, fw_result = '0;

    int checks = 0;
    int errors = 0;
    int bell_cnt = 0;

    always #2.5 clk = ~clk;

    mbox_regfile i_mbox_regfile (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .fw_bell(fw_bell), .fw_cmd(fw_cmd), .fw_operand(fw_operand),
        .fw_done(fw_done), .fw_result(fw_result), .alert(alert)
    );

    always @(negedge clk) if (!rst && fw_bell) bell_cnt <= bell_cnt + 1;

    function automatic logic exp_alert(input logic flag, input logic [7:0] ctrl);
        return flag & ~ctrl[4];
    endfunction

    function automatic logic [7:0] lane(input logic [31:0] w, input int k);
        return w[k*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, {24'h0, d}, {24'h0, exp});
    endtask

    task automatic complete(input logic [31:0] res);
        @(negedge clk);
        fw_done = 1'b1; fw_result = res;
        @(negedge clk);
        fw_done = 1'b0;
    endtask

    task automatic load_cmd(input logic [7:0] cmd, input logic [31:0] op);
        wr(8'h3F, 8'h80);
        wr(8'h38, cmd);
        for (int k = 0; k < 4; k++) wr(8'h39 + 8'(k), lane(op, k));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  ctrl;
        logic [31:0] res, op;
        logic [7:0]  cmd;
        int          snap;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 alert", alert, 0);
        chk("R1 fw_bell", fw_bell, 0);
        rd_chk("R1 ctrl", 8'h01, 8'h10);
        rd_chk("R1 status", 8'h02, 8'h00);
        rd_chk("R1 inbound0", 8'h38, 8'h00);
        rd_chk("R1 outbound1", 8'h31, 8'h00);
        rd_chk("R1 swi", 8'h40, 8'h00);

        // R2 read/write registers
        for (int i = 0; i < 8; i++) wr(8'h38 + 8'(i), 8'h5 << i ^ 8'(i));
        for (int i = 0; i < 8; i++) rd_chk("R2 inbound", 8'h38 + 8'(i), 8'h5 << i ^ 8'(i));
        wr(8'h3F, 8'h80);
        rd_chk("R2 marker", 8'h3F, 8'h80);
        chk("R2 marker no bell", fw_bell, 0);
        wr(8'h01, 8'h5A);
        rd_chk("R2 ctrl", 8'h01, 8'h5A);
        wr(8'h01, 8'h10);

        // R3 unmapped and read-only
        wr(8'h00, 8'hFF); wr(8'h03, 8'hFF); wr(8'h2F, 8'hFF); wr(8'h41, 8'hFF); wr(8'hFF, 8'hFF);
        rd_chk("R3 addr00", 8'h00, 8'h00);
        rd_chk("R3 addr03", 8'h03, 8'h00);
        rd_chk("R3 addr2F", 8'h2F, 8'h00);
        rd_chk("R3 addr41", 8'h41, 8'h00);
        rd_chk("R3 addrFF", 8'hFF, 8'h00);
        rd_chk("R3 ctrl untouched", 8'h01, 8'h10);
        wr(8'h31, 8'h77);
        rd_chk("R3 outbound ro", 8'h31, 8'h00);

        // R4 / R5 doorbell
        load_cmd(8'h03, 32'h1234_5678);
        chk("R5 fw_cmd", fw_cmd, 8'h03);
        chk("R5 fw_operand", fw_operand, 32'h1234_5678);
        wr(8'h40, 8'h02);
        chk("R4 wrong value no bell", fw_bell, 0);
        rd_chk("R2 swi", 8'h40, 8'h02);
        wr(8'h40, 8'h01);
        chk("R4 bell high", fw_bell, 1);
        @(negedge clk);
        chk("R4 bell one cycle", fw_bell, 0);

        // R6 completion
        complete(32'hA1B2_C3D4);
        rd_chk("R6 out1", 8'h31, 8'hD4);
        rd_chk("R6 out2", 8'h32, 8'hC3);
        rd_chk("R6 out3", 8'h33, 8'hB2);
        rd_chk("R6 out4", 8'h34, 8'hA1);
        rd_chk("R6 out0", 8'h30, 8'h00);
        rd_chk("R6 out5", 8'h35, 8'h00);
        rd_chk("R6 status", 8'h02, 8'h02);

        // R8 mask
        chk("R8 masked", alert, 0);
        wr(8'h01, 8'h00);
        chk("R8 unmasked", alert, 1);
        wr(8'h01, 8'h10);
        chk("R8 remasked", alert, 0);
        wr(8'h01, 8'h00);

        // R7 write-one-to-clear
        wr(8'h02, 8'h00);
        rd_chk("R7 zero keeps", 8'h02, 8'h02);
        wr(8'h02, 8'hFD);
        rd_chk("R7 other bits keep", 8'h02, 8'h02);
        wr(8'h02, 8'h02);
        rd_chk("R7 cleared", 8'h02, 8'h00);
        chk("R8 alert after clear", alert, 0);

        // R10 stray completion
        complete(32'h1111_1111);
        rd_chk("R10 out1 kept", 8'h31, 8'hD4);
        rd_chk("R10 status kept", 8'h02, 8'h00);
        chk("R10 alert", alert, 0);

        // R9 pending doorbells
        snap = bell_cnt;
        wr(8'h40, 8'h01);
        chk("R9 first bell", fw_bell, 1);
        wr(8'h40, 8'h01);
        chk("R9 busy no bell", fw_bell, 0);
        wr(8'h40, 8'h01);
        chk("R9 busy no bell 2", fw_bell, 0);
        complete(32'h0000_00AA);
        chk("R9 pending bell", fw_bell, 1);
        complete(32'h0000_00BB);
        chk("R9 no extra bell", fw_bell, 0);
        @(negedge clk);
        chk("R9 bell count", bell_cnt - snap, 2);
        rd_chk("R9 last result", 8'h31, 8'hBB);

        // R7 completion and clear in the same cycle
        wr(8'h02, 8'h02);
        wr(8'h40, 8'h01);
        @(negedge clk);
        fw_done = 1'b1; fw_result = 32'hCAFE_0001;
        bus_addr = 8'h02; bus_wdata = 8'h02; bus_wr = 1'b1;
        @(negedge clk);
        fw_done = 1'b0; bus_wr = 1'b0;
        rd_chk("R7 set wins", 8'h02, 8'h02);
        wr(8'h02, 8'h02);

        // random rounds
        for (int n = 0; n < 30; n++) begin
            cmd  = 8'($urandom);
            op   = $urandom;
            res  = $urandom;
            ctrl = ($urandom % 2) ? 8'h10 : 8'h00;
            wr(8'h01, ctrl);
            load_cmd(cmd, op);
            chk("R5 rand cmd", fw_cmd, cmd);
            chk("R5 rand operand", fw_operand, op);
            wr(8'h40, 8'h01);
            chk("R4 rand bell", fw_bell, 1);
            complete(res);
            for (int k = 0; k < 4; k++) rd_chk("R6 rand lane", 8'h31 + 8'(k), lane(res, k));
            chk("R8 rand alert", alert, exp_alert(1'b1, ctrl));
            wr(8'h02, 8'h02);
            chk("R7 rand clear alert", alert, exp_alert(1'b0, ctrl));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule